// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Read Target

This block is an I2C target that gives a bus controller read access to a small byte-wide memory inside the block. All sampling is done on the system clock. SCL and SDA pass through a two-stage synchronizer. Start and stop conditions are found by comparing each synchronized sample with the one before it. The block drives SDA as an open-drain line: it has a single enable output, and when that enable is high the line is pulled low. A wired-AND bus outside the block combines this enable with the controller's own drive.

Three read forms are supported.

- A random read uses a short write transaction that only loads the internal address pointer. A repeated start with a read request follows it.
- A current-address read starts reading at the pointer's present value.
- A sequential read continues either form. Each controller acknowledge returns the byte at the next address, and a not-acknowledge ends the stream.

The memory contents come in through a simple preload port. On the bus, the block only reads the memory.

Top module: `i2c_mem_reader`

## Requirements
- R1: A start condition (SDA falls while SCL is high) restarts address reception from the first bit, even in the middle of a byte. A stop condition (SDA rises while SCL is high) releases SDA and returns the block to idle.
- R2: The first byte after a start holds seven target-address bits, MSB first, and then a direction bit (1 means read). If the seven bits equal the `DEV_ADDR` parameter, the block holds SDA low for the whole ninth SCL clock.
- R3: If the address does not match, the block leaves SDA released in the ninth clock. It keeps SDA released for all later traffic until the next start or stop.
- R4: In a write transaction, the first byte after the target address is a byte address. The block acknowledges it and loads its low `AW` bits into the pointer. The upper bits are ignored.
- R5: Any further byte in the same write transaction gets no acknowledge, and it changes neither the memory nor the pointer.
- R6: After a write that only sets the address, a repeated start followed by a read request returns data starting at the loaded address.
- R7: A read request with no address phase returns data starting at the pointer's current value.
- R8: Data bytes are sent MSB first. The block raises its SDA drive only while SCL is low.
- R9: The pointer advances by one after each transmitted byte and wraps from the last location to 0. When the controller acknowledges a byte, the byte at the next address follows.
- R10: When the controller does not acknowledge a byte, the block releases SDA and sends nothing more until a stop or a new start. The pointer keeps its advanced value.
- R11: After reset, SDA is released and the pointer is 0.
- R12: When `load_en` is high on a clock edge, `load_data` is written into the memory at `load_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, pulls the data line low |
| load_en | input | 1 | Preload write enable |
| load_addr | input | AW | Preload write address |
| load_data | input | 8 | Preload write data |

## Verification
A table of read transactions is applied: random reads and current-address reads, each one to four bytes long. Some reads start at an address that forces the pointer to wrap, and one uses a byte address with its upper bits set. Each entry therefore tests a different aspect: a correct pointer load after a repeated start, the pointer carried over between transactions, consecutive advance with wrap, and truncation of the address. Directed cases then send a non-matching address, an extra write byte, a controller not-acknowledge followed by more clocks, and a start that cuts a byte short. After each of these, a current-address read shows that the pointer and memory are as the requirements expect.

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [7:0]    load_data
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] PTR_ONE = {{(AW-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_DACK, S_RX, S_TX, S_MACK, S_IGN} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [AW-1:0] ptr;
  logic rw, got_addr, mack;
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign rd_byte  = mem[ptr];

  always_ff @(posedge clk)
    if (load_en) mem[load_addr] <= load_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= 4'd0;
      sh       <= 8'd0;
      ptr      <= '0;
      rw       <= 1'b0;
      got_addr <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_c) begin
      st       <= S_DEV;
      cnt      <= 4'd0;
      got_addr <= 1'b0;
      rw       <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (st == S_DEV) begin
              if (sh[7:1] == DEV_ADDR) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                st     <= S_DACK;
              end else begin
                st <= S_IGN;
              end
            end else if (!got_addr) begin
              ptr      <= sh[AW-1:0];
              got_addr <= 1'b1;
              sda_oe   <= 1'b1;
              st       <= S_DACK;
            end else begin
              st <= S_IGN;
            end
          end
        end
        S_DACK: begin
          if (scl_fall) begin
            if (rw) begin
              sda_oe <= ~rd_byte[7];
              sh     <= {rd_byte[6:0], 1'b0};
              cnt    <= 4'd1;
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              cnt    <= 4'd0;
              st     <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + PTR_ONE;
              st     <= S_MACK;
            end else begin
              sda_oe <= ~sh[7];
              sh     <= {sh[6:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              sda_oe <= ~rd_byte[7];
              sh     <= {rd_byte[6:0], 1'b0};
              cnt    <= 4'd1;
              st     <= S_TX;
            end else begin
              st <= S_IGN;
            end
          end
        end
        default: ;
      endcase
    end

  assert_start_rearm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == S_DEV && cnt == 4'd0 && !sda_oe));

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE && !sda_oe));

  assert_ack_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DACK) |-> sda_oe);

  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_oe);

  assert_drive_low_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> (ptr == $past(ptr) + PTR_ONE || $past(st) == S_RX));

  assert_nack_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK && scl_fall && !mack && !start_c && !stop_c) |=> (st == S_IGN && !sda_oe));
endmodule

// File: tb/tb_i2c_mem_reader.sv
module tb_i2c_mem_reader;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [6:0] DEV = 7'h50;
  localparam int NV = 6;
  // {random, byte address, byte count}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 8'h00, 4'd1},
    {1'b1, 8'h05, 4'd1},
    {1'b1, 8'h0E, 4'd4},
    {1'b0, 8'h00, 4'd2},
    {1'b1, 8'h47, 4'd3},
    {1'b1, 8'h0F, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_oe = 1'b0;
  logic dut_oe;
  logic sda_line;
  logic load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [7:0] load_data = 8'd0;
  logic [7:0] mdl [DEPTH];
  int mptr = 0;
  int nchk = 0;
  int nfail = 0;
  int viol = 0;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  assign sda_line = !(m_oe || dut_oe);

  always #(CLK_P/2) clk = ~clk;

  i2c_mem_reader #(.DEV_ADDR(DEV), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(dut_oe),
    .load_en(load_en), .load_addr(load_addr), .load_data(load_data));

  always @(negedge clk) begin
    if (scl && dut_oe && !prev_oe) viol++;
    prev_oe = dut_oe;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic r);
    wclk(3); m_oe = !b;
    wclk(5); scl = 1'b1;
    wclk(4); r = sda_line;
    wclk(4); scl = 1'b0;
  endtask

  task automatic do_start();
    if (!scl) begin
      wclk(3); m_oe = 1'b0;
      wclk(5); scl = 1'b1;
    end
    wclk(4); m_oe = 1'b1;
    wclk(4); scl = 1'b0;
  endtask

  task automatic do_stop();
    wclk(3); m_oe = 1'b1;
    wclk(5); scl = 1'b1;
    wclk(4); m_oe = 1'b0;
    wclk(4);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(d[i], r);
    bitx(1'b1, r);
    ack = !r;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, r);
      d[i] = r;
    end
    bitx(!give_ack, r);
  endtask

  task automatic load(input int a, input logic [7:0] v);
    @(negedge clk);
    load_en = 1'b1; load_addr = a[AW-1:0]; load_data = v;
    @(negedge clk);
    load_en = 1'b0;
    mdl[a] = v;
  endtask

  task automatic rd_seq(input logic rnd, input logic [7:0] a, input int n);
    logic ack;
    logic [7:0] d;
    do_start();
    wbyte({DEV, !rnd}, ack);
    chk("R2 target address ack", ack, 1);
    if (rnd) begin
      wbyte(a, ack);
      chk("R4 byte address ack", ack, 1);
      mptr = a & (DEPTH - 1);
      do_start();
      wbyte({DEV, 1'b1}, ack);
      chk("R6 read request ack after repeated start", ack, 1);
    end
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, d);
      chk(rnd ? "R9 R6 random/sequential data" : "R9 R7 current/sequential data", d, mdl[mptr]);
      mptr = (mptr + 1) % DEPTH;
    end
    do_stop();
    chk("R1 SDA released after stop", dut_oe, 0);
  endtask

  initial begin
    logic ack;
    logic r;
    logic [7:0] d;
    wclk(4);
    chk("R11 SDA released in reset", dut_oe, 0);
    rst_n = 1'b1;
    wclk(2);
    chk("R11 SDA released after reset", dut_oe, 0);
    for (int i = 0; i < DEPTH; i++) load(i, 8'((i * 29 + 7) ^ 8'hA0));

    // R11 R7: first table entry is a current-address read from pointer 0
    for (int v = 0; v < NV; v++) rd_seq(VEC[v][12], VEC[v][11:4], int'(VEC[v][3:0]));

    // R3: non-matching address
    do_start();
    wbyte({7'h23, 1'b1}, ack);
    chk("R3 no ack for foreign address", ack, 0);
    rbyte(1'b0, d);
    chk("R3 SDA stays released", d, 8'hFF);
    do_stop();
    rd_seq(1'b0, 8'h00, 1);

    // R5: extra write byte refused
    do_start();
    wbyte({DEV, 1'b0}, ack);
    wbyte(8'h09, ack);
    chk("R4 address ack", ack, 1);
    wbyte(8'hAA, ack);
    chk("R5 extra write byte not acked", ack, 0);
    do_stop();
    mptr = 9;
    rd_seq(1'b0, 8'h00, 1);
    chk("R5 memory untouched", mdl[9], 8'((9 * 29 + 7) ^ 8'hA0));

    // R10: controller nack then more clocks
    do_start();
    wbyte({DEV, 1'b1}, ack);
    chk("R2 read ack", ack, 1);
    rbyte(1'b0, d);
    chk("R10 byte before nack", d, mdl[mptr]);
    mptr = (mptr + 1) % DEPTH;
    rbyte(1'b0, d);
    chk("R10 nothing sent after nack", d, 8'hFF);
    do_stop();
    rd_seq(1'b0, 8'h00, 1);

    // R1: start in mid byte restarts address reception
    do_start();
    for (int i = 7; i >= 4; i--) bitx(DEV[i-1], r);
    do_start();
    wbyte({DEV, 1'b1}, ack);
    chk("R1 ack after start mid byte", ack, 1);
    rbyte(1'b0, d);
    chk("R1 data after restart", d, mdl[mptr]);
    mptr = (mptr + 1) % DEPTH;
    do_stop();

    // R12: preload port
    load(3, 8'h5A);
    rd_seq(1'b1, 8'h03, 1);
    chk("R12 preloaded value reads back", mdl[3], 8'h5A);

    // R9: wrap from last location
    rd_seq(1'b1, 8'h0F, 3);

    chk("R8 SDA drive raised only while SCL low", viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule